// File: doc/BRIEF.md
# ADC Fast-Detect Threshold Monitor

This block watches a stream of signed converter samples, one per clock and qualified by a valid flag, and reports how large the signal is. For each sample it forms a saturated absolute magnitude and sorts that magnitude into one of eight coarse bands. From the magnitude and the band it produces a set of indicators that external logic can use, for example to switch in an attenuator before the converter is overdriven. The indicators are a fast-detect level code, a coarse upper-threshold flag, fine upper and lower threshold flags against programmable full-resolution limits, and an overrange flag.

Each indicator comes out with its own fixed pipeline latency. The coarse flag is the quickest path and is stretched so that a single-sample excursion is still at least two cycles wide. The fine flags and the overrange flag share one long latency, so they stay aligned with each other. All thresholds and the output mode are plain configuration inputs that are expected to stay steady while samples flow.

Top module: `adc_level_monitor`

## Requirements
- R1: The magnitude is |sample| on 13 bits, with the most negative code saturating to 8191. The band code is the number of band edges the magnitude reaches or exceeds, where the edges are 517, 1543, 2591, 3659, 4607, 5635 and 6659. This gives codes 0 to 7.
- R2: With mode 3'b001 the fast-detect output carries the full 3-bit band code of a sample six clock cycles after that sample is presented.
- R3: With mode 3'b010 or 3'b011 the fast-detect output carries bits [2:1] of the band code in bits [2:1], and bit 0 reads zero. With any other mode value except 3'b001, all three bits read zero.
- R4: The coarse flag rises two clock cycles after a sample whose band code is strictly greater than the 3-bit coarse threshold. An equal code does not raise it.
- R5: Once raised, the coarse flag stays high for at least two cycles. It then stays high for as long as consecutive samples keep the band code above the threshold.
- R6: The fine upper flag is high twelve cycles after a sample whose magnitude is strictly greater than the 13-bit upper limit.
- R7: The fine lower flag is high twelve cycles after a sample whose magnitude is strictly less than the 13-bit lower limit.
- R8: The overrange flag is high twelve cycles after a sample equal to +8191 or -8192, and only for such samples.
- R9: A cycle with the valid flag low counts as magnitude zero and raises no flag, whatever the sample value and the limits.
- R10: While reset is held, and through the pipeline fill after reset with idle input, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 14 | Two's-complement converter sample |
| cfg_mode | input | 3 | Fast-detect output mode |
| cfg_coarse_thr | input | 3 | Coarse upper threshold, compared with the band code |
| cfg_fine_hi | input | 13 | Fine upper limit on the magnitude |
| cfg_fine_lo | input | 13 | Fine lower limit on the magnitude |
| fd_code | output | 3 | Fast-detect level code, formatted by the mode |
| coarse_flag | output | 1 | Stretched coarse upper-threshold flag |
| fine_hi_flag | output | 1 | Fine upper-threshold flag |
| fine_lo_flag | output | 1 | Fine lower-threshold flag |
| ovr_flag | output | 1 | Overrange flag |

## Verification
Each result has a fixed due cycle counted from the clock edge that captures the sample: two for the coarse flag, six for the level code, and twelve for the fine flags and the overrange flag. Every scenario injects an isolated burst into an idle stream and records all outputs on each falling edge for twenty cycles. It checks the due cycle for the expected value and the cycle just before it for the idle value, so a latency that is off by one in either direction is caught. The coarse flag is also checked one cycle after its minimum width, and the bursts are spaced far enough apart that the pipeline is empty between them.

// File: rtl/adc_lvl_pkg.sv
package adc_lvl_pkg;

  localparam int NUM_EDGES = 7;
  localparam int CODE_W    = $clog2(NUM_EDGES + 1);
  localparam int MODE_W    = 3;
  localparam int FRAC_W    = 16;

  localparam logic [MODE_W-1:0] MODE_FULL   = 3'b001;
  localparam logic [MODE_W-1:0] MODE_UPPER2 = 3'b010;
  localparam logic [MODE_W-1:0] MODE_UPPER3 = 3'b011;

  // Band edges as fractions of full scale, Q0.16 (-24 .. -1.8 dBFS)
  localparam longint EDGE_FRAC [NUM_EDGES] =
    '{4135, 12345, 20724, 29274, 36854, 45079, 53270};

  typedef struct packed {
    logic ovr;
    logic fhi;
    logic flo;
  } slow_flags_t;

  // Edge magnitude for a magnitude width, rounded to nearest
  function automatic longint edge_level(input int idx, input int mag_w);
    longint scaled;
    scaled = EDGE_FRAC[idx] << mag_w;
    return (scaled + (longint'(1) << (FRAC_W - 1))) >> FRAC_W;
  endfunction

endpackage

// File: rtl/adc_lvl_front.sv
module adc_lvl_front
  import adc_lvl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [MAG_W-1:0]    fine_hi,
  input  logic [MAG_W-1:0]    fine_lo,
  output logic [CODE_W-1:0]   code_q,
  output slow_flags_t         flags_q
);

  logic [SAMPLE_W-1:0] abs_val;
  logic [MAG_W-1:0]    mag;
  logic                at_rail;
  logic [CODE_W-1:0]   code_n;
  slow_flags_t         flags_n;

  always_comb begin
    abs_val = in_sample[SAMPLE_W-1] ? (~in_sample + 1'b1) : in_sample;
    // most negative code folds to 2^MAG_W; saturate it
    if (!in_valid)                 mag = '0;
    else if (abs_val[SAMPLE_W-1])  mag = '1;
    else                           mag = abs_val[MAG_W-1:0];

    at_rail = (in_sample == {1'b0, {(SAMPLE_W-1){1'b1}}}) ||
              (in_sample == {1'b1, {(SAMPLE_W-1){1'b0}}});

    code_n = '0;
    for (int i = 0; i < NUM_EDGES; i++) begin
      if (longint'(mag) >= edge_level(i, MAG_W)) code_n = code_n + 1'b1;
    end

    flags_n.ovr = in_valid && at_rail;
    flags_n.fhi = in_valid && (mag > fine_hi);
    flags_n.flo = in_valid && (mag < fine_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      flags_q <= '0;
    end else begin
      code_q  <= code_n;
      flags_q <= flags_n;
    end
  end

  AST_OVR_TOP_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.ovr |-> (code_q == {CODE_W{1'b1}}));  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (code_q == '0) && (flags_q == '0));  // R9

endmodule

// File: rtl/adc_lvl_delay.sv
module adc_lvl_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [DEPTH-1:0][WIDTH-1:0] pipe_q;
      logic [DEPTH-1:0][WIDTH-1:0] pipe_n;

      always_comb begin
        pipe_n[0] = d;
        for (int i = 1; i < DEPTH; i++) pipe_n[i] = pipe_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_n;
      end

      assign q = pipe_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/adc_lvl_stretch.sv
module adc_lvl_stretch
  import adc_lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] thr,
  output logic              flag_q
);

  logic hit;
  logic first_q;
  logic flag_n;
  logic first_n;

  always_comb begin
    hit = (code > thr);
    if (hit) begin
      flag_n  = 1'b1;
      first_n = !flag_q;
    end else if (flag_q && first_q) begin
      flag_n  = 1'b1;
      first_n = 1'b0;
    end else begin
      flag_n  = 1'b0;
      first_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      first_q <= first_n;
    end
  end

  AST_CU_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |=> flag_q);  // R5

  AST_CU_TRACKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);  // R4

endmodule

// File: rtl/adc_level_monitor.sv
module adc_level_monitor
  import adc_lvl_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int FD_LAT   = 6,
  parameter int SLOW_LAT = 12,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [2:0]          cfg_mode,
  input  logic [2:0]          cfg_coarse_thr,
  input  logic [MAG_W-1:0]    cfg_fine_hi,
  input  logic [MAG_W-1:0]    cfg_fine_lo,
  output logic [2:0]          fd_code,
  output logic                coarse_flag,
  output logic                fine_hi_flag,
  output logic                fine_lo_flag,
  output logic                ovr_flag
);

  localparam int FLAGS_W = $bits(slow_flags_t);

  logic [CODE_W-1:0] code_s1;
  slow_flags_t       flags_s1;
  logic [CODE_W-1:0] code_late;
  slow_flags_t       flags_late;

  adc_lvl_front #(.SAMPLE_W(SAMPLE_W)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .fine_hi  (cfg_fine_hi),
    .fine_lo  (cfg_fine_lo),
    .code_q   (code_s1),
    .flags_q  (flags_s1)
  );

  adc_lvl_stretch u_coarse (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code_s1),
    .thr   (cfg_coarse_thr),
    .flag_q(coarse_flag)
  );

  adc_lvl_delay #(.WIDTH(CODE_W), .DEPTH(FD_LAT - 1)) u_fd_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (code_s1),
    .q    (code_late)
  );

  adc_lvl_delay #(.WIDTH(FLAGS_W), .DEPTH(SLOW_LAT - 1)) u_slow_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (flags_s1),
    .q    (flags_late)
  );

  always_comb begin
    unique case (cfg_mode)
      MODE_FULL:                fd_code = code_late;
      MODE_UPPER2, MODE_UPPER3: fd_code = {code_late[CODE_W-1:1], 1'b0};
      default:                  fd_code = '0;
    endcase
  end

  assign fine_hi_flag = flags_late.fhi;
  assign fine_lo_flag = flags_late.flo;
  assign ovr_flag     = flags_late.ovr;

  AST_FD_LSB_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_UPPER2 || cfg_mode == MODE_UPPER3) |-> !fd_code[0]);  // R3

endmodule

// File: tb/adc_level_monitor_bench.sv
module adc_level_monitor_bench;

  localparam int CAP = 20;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [13:0] in_sample;
  logic [2:0]  cfg_mode;
  logic [2:0]  cfg_coarse_thr;
  logic [12:0] cfg_fine_hi;
  logic [12:0] cfg_fine_lo;
  logic [2:0]  fd_code;
  logic        coarse_flag;
  logic        fine_hi_flag;
  logic        fine_lo_flag;
  logic        ovr_flag;

  int checks;
  int fails;
  bit done;

  logic [2:0] c_fd  [0:CAP];
  logic       c_cu  [0:CAP];
  logic       c_fhi [0:CAP];
  logic       c_flo [0:CAP];
  logic       c_ovr [0:CAP];

  adc_level_monitor u_adc_level_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sample     (in_sample),
    .cfg_mode      (cfg_mode),
    .cfg_coarse_thr(cfg_coarse_thr),
    .cfg_fine_hi   (cfg_fine_hi),
    .cfg_fine_lo   (cfg_fine_lo),
    .fd_code       (fd_code),
    .coarse_flag   (coarse_flag),
    .fine_hi_flag  (fine_hi_flag),
    .fine_lo_flag  (fine_lo_flag),
    .ovr_flag      (ovr_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ref_mag(input int s);
    int a;
    a = (s < 0) ? -s : s;
    return (a > 8191) ? 8191 : a;
  endfunction

  function automatic int ref_band(input int m);
    int edges [7] = '{517, 1543, 2591, 3659, 4607, 5635, 6659};
    int n = 0;
    foreach (edges[i]) if (m >= edges[i]) n++;
    return n;
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Starts at a falling edge; drives for `hold` cycles, then idles; records CAP cycles.
  task automatic launch(input logic v, input int s, input int hold);
    for (int k = 1; k <= CAP; k++) begin
      if (k <= hold) begin
        in_valid  = v;
        in_sample = 14'(s);
      end else begin
        in_valid  = 1'b0;
        in_sample = '0;
      end
      @(negedge clk);
      c_fd[k]  = fd_code;
      c_cu[k]  = coarse_flag;
      c_fhi[k] = fine_hi_flag;
      c_flo[k] = fine_lo_flag;
      c_ovr[k] = ovr_flag;
    end
  endtask

  task automatic set_default_cfg();
    cfg_mode       = 3'b001;
    cfg_coarse_thr = 3'd7;
    cfg_fine_hi    = 13'd8191;
    cfg_fine_lo    = 13'd0;
  endtask

  task automatic test_reset();
    set_default_cfg();
    cfg_coarse_thr = 3'd0;
    rst_n     = 1'b0;
    in_valid  = 1'b1;
    in_sample = 14'd8191;
    repeat (4) @(negedge clk);
    check("R10", "outputs in reset",
          int'({fd_code, coarse_flag, fine_hi_flag, fine_lo_flag, ovr_flag}), 0);
    in_valid  = 1'b0;
    in_sample = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      if ({fd_code, coarse_flag, fine_hi_flag, fine_lo_flag, ovr_flag} != '0)
        check("R10", $sformatf("outputs at fill cycle %0d", k),
              int'({fd_code, coarse_flag, fine_hi_flag, fine_lo_flag, ovr_flag}), 0);
    end
    check("R10", "outputs after fill",
          int'({fd_code, coarse_flag, fine_hi_flag, fine_lo_flag, ovr_flag}), 0);
    set_default_cfg();
  endtask

  task automatic test_bands();
    int samples [14] = '{0, 516, 517, 1542, 1543, -2591, 3659, 4606, 4607,
                         -5635, 6658, 6659, 8191, -8192};
    set_default_cfg();
    foreach (samples[i]) begin
      launch(1'b1, samples[i], 1);
      // R1 band and R2 latency of six
      check("R1", $sformatf("band of %0d", samples[i]), int'(c_fd[6]),
            ref_band(ref_mag(samples[i])));
      check("R2", $sformatf("code early for %0d", samples[i]), int'(c_fd[5]), 0);
      check("R2", $sformatf("code late for %0d", samples[i]), int'(c_fd[7]), 0);
    end
  endtask

  task automatic test_modes();
    set_default_cfg();
    cfg_mode = 3'b010; launch(1'b1, 6659, 1);
    check("R3", "mode 010 code 7", int'(c_fd[6]), 6);
    cfg_mode = 3'b011; launch(1'b1, 4607, 1);
    check("R3", "mode 011 code 5", int'(c_fd[6]), 4);
    cfg_mode = 3'b010; launch(1'b1, 3659, 1);
    check("R3", "mode 010 code 4", int'(c_fd[6]), 4);
    cfg_mode = 3'b011; launch(1'b1, 517, 1);
    check("R3", "mode 011 code 1", int'(c_fd[6]), 0);
    cfg_mode = 3'b000; launch(1'b1, 6659, 1);
    check("R3", "mode 000 code 7", int'(c_fd[6]), 0);
    cfg_mode = 3'b101; launch(1'b1, 6659, 1);
    check("R3", "mode 101 code 7", int'(c_fd[6]), 0);
    cfg_mode = 3'b111; launch(1'b1, -8192, 1);
    check("R3", "mode 111 code 7", int'(c_fd[6]), 0);
    set_default_cfg();
  endtask

  task automatic test_coarse();
    set_default_cfg();
    cfg_coarse_thr = 3'd3;
    launch(1'b1, 3659, 1);
    check("R4", "single code 4, cycle 1", int'(c_cu[1]), 0);
    check("R4", "single code 4, cycle 2", int'(c_cu[2]), 1);
    check("R5", "single code 4, cycle 3", int'(c_cu[3]), 1);
    check("R5", "single code 4, cycle 4", int'(c_cu[4]), 0);
    launch(1'b1, 2591, 1);
    check("R4", "equal code 3, cycle 2", int'(c_cu[2]), 0);
    check("R4", "equal code 3, cycle 3", int'(c_cu[3]), 0);
    launch(1'b1, -6659, 5);
    check("R4", "burst, cycle 1", int'(c_cu[1]), 0);
    for (int k = 2; k <= 6; k++)
      check("R5", $sformatf("burst, cycle %0d", k), int'(c_cu[k]), 1);
    check("R5", "burst, cycle 7", int'(c_cu[7]), 0);
    cfg_coarse_thr = 3'd7;
    launch(1'b1, 8191, 1);
    check("R4", "threshold 7, top band", int'(c_cu[2]), 0);
    set_default_cfg();
  endtask

  task automatic test_fine();
    set_default_cfg();
    cfg_fine_hi = 13'd4000;
    cfg_fine_lo = 13'd1000;
    launch(1'b1, 4001, 1);
    check("R6", "4001 > 4000 at 12", int'(c_fhi[12]), 1);
    check("R6", "4001 early at 11", int'(c_fhi[11]), 0);
    check("R6", "4001 late at 13", int'(c_fhi[13]), 0);
    check("R7", "4001 lower flag", int'(c_flo[12]), 0);
    launch(1'b1, -4000, 1);
    check("R6", "equal to upper", int'(c_fhi[12]), 0);
    launch(1'b1, -999, 1);
    check("R7", "999 < 1000 at 12", int'(c_flo[12]), 1);
    check("R7", "999 early at 11", int'(c_flo[11]), 0);
    launch(1'b1, 1000, 1);
    check("R7", "equal to lower", int'(c_flo[12]), 0);
    set_default_cfg();
  endtask

  task automatic test_ovr();
    set_default_cfg();
    launch(1'b1, 8191, 1);
    check("R8", "+8191 at 12", int'(c_ovr[12]), 1);
    check("R8", "+8191 early at 11", int'(c_ovr[11]), 0);
    check("R8", "+8191 late at 13", int'(c_ovr[13]), 0);
    launch(1'b1, -8192, 1);
    check("R8", "-8192 at 12", int'(c_ovr[12]), 1);
    launch(1'b1, 8190, 1);
    check("R8", "+8190 at 12", int'(c_ovr[12]), 0);
    launch(1'b1, -8191, 1);
    check("R8", "-8191 at 12", int'(c_ovr[12]), 0);
  endtask

  task automatic test_invalid();
    int seen;
    set_default_cfg();
    cfg_coarse_thr = 3'd0;
    cfg_fine_hi    = 13'd0;
    cfg_fine_lo    = 13'd8191;
    launch(1'b0, 8191, 3);
    seen = 0;
    for (int k = 1; k <= CAP; k++)
      seen = seen | int'({c_fd[k], c_cu[k], c_fhi[k], c_flo[k], c_ovr[k]});
    check("R9", "any output for invalid rail samples", seen, 0);
    launch(1'b1, 0, 1);
    check("R9", "valid zero, upper flag", int'(c_fhi[12]), 0);
    check("R7", "valid zero, lower flag", int'(c_flo[12]), 1);
    set_default_cfg();
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    set_default_cfg();
    @(negedge clk);
    test_reset();
    test_bands();
    test_modes();
    test_coarse();
    test_fine();
    test_ovr();
    test_invalid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule